// File: doc/BRIEF.md
# Cache Linefill Wrapping Read Requester

When the cache misses, this block fetches the whole 32-byte line that holds the missed address. It sends one read burst on an AXI read address channel. The burst is a wrapping burst of four 64-bit beats, and its first beat is the doubleword that missed. As the beats come back on the read data channel, the block writes each one into its own doubleword slot of a line buffer. The wrapped beat order therefore ends up as a line in natural order.

The block raises a one-cycle flag when the critical (missed) doubleword arrives, so the pipeline can restart early. It raises a one-cycle completion strobe when the last beat has been stored. Only cacheable, normal, non-shared memory may be filled this way. A request for any other memory class is refused and reported. Any error response inside a burst marks the finished line as bad.

Top module: `linefill_wrap_top`

## Requirements
- R1: Every issued read request has burst type WRAP (`m_arburst` = 2'b10), beat size 8 bytes (`m_arsize` = 3) and length four beats (`m_arlen` = 3).
- R2: `m_araddr` is the accepted miss address with bits [2:0] cleared. It therefore lies inside the 32-byte line of the miss.
- R3: A request with `miss_cnns` low, seen while idle, issues no read request and sets `fill_busy` to nothing. It pulses `req_reject` for exactly one cycle, in the cycle after the request.
- R4: Once `m_arvalid` is raised, it stays high with an unchanged `m_araddr` until the cycle in which `m_arready` is seen.
- R5: Let the start slot be miss address bits [4:3]. Beat k of the burst is stored in slot (start + k) mod 4, and slot i is `line_data[64*i+63 : 64*i]`.
- R6: `crit_pulse` is high for exactly one cycle per linefill, in the cycle after the first data beat is accepted.
- R7: `line_done` is high for one cycle, in the cycle after the beat with `m_rlast` is accepted. In that same cycle `fill_busy` is low.
- R8: `line_err` is set by any beat whose `m_rresp` is not OKAY (2'b00). It stays set through `line_done` and is cleared when the next linefill is accepted.
- R9: A request arriving while `fill_busy` is high is ignored. It issues no new read request and no rejection, and it leaves the fill in progress unchanged.
- R10: After reset, `m_arvalid`, `m_rready`, `fill_busy`, `crit_pulse`, `line_done`, `line_err` and `req_reject` are all low.
- R11: `m_rready` is high only after the address handshake and until the last beat, and never while `m_arvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Linefill request |
| miss_addr | input | ADDR_W | Byte address that missed |
| miss_cnns | input | 1 | Memory class is cacheable normal non-shared |
| fill_busy | output | 1 | A linefill is in progress |
| req_reject | output | 1 | One-cycle pulse: request refused for its memory class |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address (doubleword aligned) |
| m_arlen | output | 8 | Burst length minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 64 | Read data beat |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of burst |
| line_data | output | 256 | Assembled line, slot 0 in the low bits |
| crit_pulse | output | 1 | Critical doubleword has arrived |
| line_done | output | 1 | Line complete strobe |
| line_err | output | 1 | Sticky error for the current linefill |

## Verification
Two things can happen on the same final beat: the error flag can be updated, and the completion strobe can fire. A slave error placed only on the `m_rlast` beat tests this. The bench then requires `line_err` to be high in the very cycle `line_done` rises, not one cycle later. The first beat is covered the same way. An error response on beat zero must still let `crit_pulse` fire, and the error must still be held at completion.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int unsigned DW         = 64;
    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned BEAT_BYTES = DW / 8;
    localparam int unsigned BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int unsigned SLOT_W     = $clog2(BEATS);
    localparam int unsigned BOFF_W     = $clog2(BEAT_BYTES);
    localparam int unsigned LINE_W     = LINE_BYTES * 8;

    localparam logic [1:0] BURST_WRAP = 2'b10;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [7:0] WRAP_LEN   = 8'(BEATS - 1);
    localparam logic [2:0] WRAP_SIZE  = 3'(BOFF_W);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } fill_st_e;

    typedef struct packed {
        logic [7:0] len;
        logic [2:0] size;
        logic [1:0] burst;
    } ar_ctl_t;

    typedef struct packed {
        logic       fire;
        logic       last;
        logic [1:0] resp;
    } beat_evt_t;

    function automatic logic [SLOT_W-1:0] wrap_slot(
        input logic [SLOT_W-1:0] start,
        input logic [SLOT_W-1:0] k
    );
        return start + k;
    endfunction

    function automatic ar_ctl_t linefill_ctl();
        ar_ctl_t c;
        c.len   = WRAP_LEN;
        c.size  = WRAP_SIZE;
        c.burst = BURST_WRAP;
        return c;
    endfunction
endpackage

// File: rtl/lf_addr_gen.sv
module lf_addr_gen
    import lf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [ADDR_W-1:0]     miss_addr,
    output logic [ADDR_W-1:0]     ar_addr,
    output logic [SLOT_W-1:0]     start_slot
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= {miss_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
        end
    end

    assign ar_addr    = addr_q;
    assign start_slot = addr_q[BOFF_W +: SLOT_W];
endmodule

// File: rtl/lf_beat_collect.sv
module lf_beat_collect
    import lf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [SLOT_W-1:0] start_slot,
    input  beat_evt_t         evt,
    input  logic [DW-1:0]     rdata,
    output logic [LINE_W-1:0] line_data,
    output logic              crit_pulse,
    output logic              line_done,
    output logic              line_err
);
    logic [SLOT_W-1:0] beat_cnt;
    logic [SLOT_W-1:0] tgt_slot;
    logic              crit_q, done_q, err_q;

    assign tgt_slot = wrap_slot(start_slot, beat_cnt);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beat_cnt <= '0;
        end else if (evt.fire) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    for (genvar s = 0; s < BEATS; s++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (evt.fire && tgt_slot == SLOT_W'(s)) begin
                slot_q <= rdata;
            end
        end
        assign line_data[s*DW +: DW] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crit_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            crit_q <= evt.fire && (beat_cnt == '0);
            done_q <= evt.fire && evt.last;
            if (clear) begin
                err_q <= 1'b0;
            end else if (evt.fire && evt.resp != RESP_OKAY) begin
                err_q <= 1'b1;
            end
        end
    end

    assign crit_pulse = crit_q;
    assign line_done  = done_q;
    assign line_err   = err_q;
endmodule

// File: rtl/linefill_wrap_top.sv
module linefill_wrap_top
    import lf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  miss_valid,
    input  logic [ADDR_W-1:0]     miss_addr,
    input  logic                  miss_cnns,
    output logic                  fill_busy,
    output logic                  req_reject,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    output logic [ADDR_W-1:0]     m_araddr,
    output logic [7:0]            m_arlen,
    output logic [2:0]            m_arsize,
    output logic [1:0]            m_arburst,
    input  logic                  m_rvalid,
    output logic                  m_rready,
    input  logic [63:0]           m_rdata,
    input  logic [1:0]            m_rresp,
    input  logic                  m_rlast,
    output logic [255:0]          line_data,
    output logic                  crit_pulse,
    output logic                  line_done,
    output logic                  line_err
);
    fill_st_e          st_q, st_d;
    logic              accept, refuse, ar_fire;
    logic              reject_q;
    logic [SLOT_W-1:0] start_slot;
    beat_evt_t         evt;
    ar_ctl_t           ctl;

    assign accept  = (st_q == ST_IDLE) && miss_valid && miss_cnns;
    assign refuse  = (st_q == ST_IDLE) && miss_valid && !miss_cnns;
    assign ar_fire = (st_q == ST_ADDR) && m_arready;

    assign evt.fire = (st_q == ST_DATA) && m_rvalid;
    assign evt.last = m_rlast;
    assign evt.resp = m_rresp;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)              st_d = ST_ADDR;
            ST_ADDR: if (ar_fire)             st_d = ST_DATA;
            ST_DATA: if (evt.fire && evt.last) st_d = ST_IDLE;
            default:                           st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            reject_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            reject_q <= refuse;
        end
    end

    lf_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .miss_addr  (miss_addr),
        .ar_addr    (m_araddr),
        .start_slot (start_slot)
    );

    lf_beat_collect u_collect (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .start_slot (start_slot),
        .evt        (evt),
        .rdata      (m_rdata),
        .line_data  (line_data),
        .crit_pulse (crit_pulse),
        .line_done  (line_done),
        .line_err   (line_err)
    );

    assign ctl        = linefill_ctl();
    assign m_arlen    = ctl.len;
    assign m_arsize   = ctl.size;
    assign m_arburst  = ctl.burst;
    assign m_arvalid  = (st_q == ST_ADDR);
    assign m_rready   = (st_q == ST_DATA);
    assign fill_busy  = (st_q != ST_IDLE);
    assign req_reject = reject_q;
endmodule

// File: rtl/linefill_wrap_chk.sv
module linefill_wrap_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              miss_cnns,
    input logic              fill_busy,
    input logic              req_reject,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic [7:0]        m_arlen,
    input logic [2:0]        m_arsize,
    input logic [1:0]        m_arburst,
    input logic              m_rvalid,
    input logic              m_rready,
    input logic              m_rlast,
    input logic              crit_pulse,
    input logic              line_done
);
    p_ar_fields_r1: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> (m_arburst == 2'b10 && m_arsize == 3'd3 && m_arlen == 8'd3));

    p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> (m_araddr[2:0] == 3'b000));

    p_reject_no_req_r3: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> (!m_arvalid && !fill_busy));

    p_ar_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    p_crit_single_r6: assert property (@(posedge clk) disable iff (rst)
        crit_pulse |=> !crit_pulse);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (m_rvalid && m_rready && m_rlast) |=> (line_done && !fill_busy));

    p_busy_no_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (fill_busy && miss_valid && !miss_cnns) |=> !req_reject);

    p_rready_phase_r11: assert property (@(posedge clk) disable iff (rst)
        m_rready |-> (!m_arvalid && fill_busy));
endmodule

bind linefill_wrap_top linefill_wrap_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/linefill_wrap_top_tb.sv
module linefill_wrap_top_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         miss_valid, miss_cnns;
    logic [31:0]  miss_addr;
    logic         fill_busy, req_reject;
    logic         m_arvalid, m_arready;
    logic [31:0]  m_araddr;
    logic [7:0]   m_arlen;
    logic [2:0]   m_arsize;
    logic [1:0]   m_arburst;
    logic         m_rvalid, m_rready, m_rlast;
    logic [63:0]  m_rdata;
    logic [1:0]   m_rresp;
    logic [255:0] line_data;
    logic         crit_pulse, line_done, line_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    linefill_wrap_top u_dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_val(input int tag, input int k);
        return {32'(tag), 32'hC0DE_0000 + 32'(k)};
    endfunction

    task automatic t_reset;
        rst = 1'b1; miss_valid = 0; miss_cnns = 0; miss_addr = '0;
        m_arready = 0; m_rvalid = 0; m_rlast = 0; m_rdata = '0; m_rresp = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk({m_arvalid, m_rready, fill_busy, crit_pulse, line_done, line_err, req_reject} == '0,
            "R10 reset outputs low",
            {m_arvalid, m_rready, fill_busy, crit_pulse, line_done, line_err, req_reject}, 0);
    endtask

    // One full linefill; errmask bit k gives beat k a SLVERR; ign drives a
    // competing request (wrong class) through the whole data phase.
    task automatic t_fill(input logic [31:0] addr, input int ar_stall,
                          input logic [3:0] errmask, input logic ign, input int tag);
        int s;
        s = addr[4:3];
        @(negedge clk);
        miss_valid = 1; miss_cnns = 1; miss_addr = addr;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 0;
        chk(m_arvalid && fill_busy, "R2 request issued", m_arvalid, 1);
        chk(m_araddr == {addr[31:3], 3'b000}, "R2 aligned address", m_araddr, {addr[31:3], 3'b000});
        chk(m_arburst == 2'b10 && m_arsize == 3'd3 && m_arlen == 8'd3, "R1 burst fields",
            {m_arburst, m_arsize, m_arlen}, {2'b10, 3'd3, 8'd3});
        chk(!m_rready, "R11 rready low in address phase", m_rready, 0);
        for (int i = 0; i < ar_stall; i++) begin
            @(posedge clk); @(negedge clk);
            chk(m_arvalid && m_araddr == {addr[31:3], 3'b000}, "R4 request held while stalled",
                m_araddr, {addr[31:3], 3'b000});
        end
        m_arready = 1;
        @(posedge clk); @(negedge clk);
        m_arready = 0;
        chk(m_rready && !m_arvalid, "R11 rready in data phase", {m_rready, m_arvalid}, 2'b10);
        if (ign) begin
            miss_valid = 1; miss_cnns = 0; miss_addr = 32'hFFFF_FFE0;
        end
        for (int k = 0; k < 4; k++) begin
            m_rvalid = 1; m_rdata = beat_val(tag, k);
            m_rresp = errmask[k] ? 2'b10 : 2'b00; m_rlast = (k == 3);
            @(posedge clk); @(negedge clk);
            if (k == 3) miss_valid = 0;
            chk(crit_pulse == (k == 0), "R6 critical flag timing", crit_pulse, k == 0);
            chk(line_done == (k == 3), "R7 done timing", line_done, k == 3);
            if (ign) chk(!req_reject, "R9 no reject while busy", req_reject, 0);
        end
        m_rvalid = 0; m_rlast = 0; m_rresp = 2'b00;
        chk(!fill_busy, "R7 idle at done", fill_busy, 0);
        chk(line_err == (errmask != 0), "R8 error at done", line_err, errmask != 0);
        for (int k = 0; k < 4; k++) begin
            int sl;
            sl = (s + k) % 4;
            chk(line_data[sl*64 +: 64] == beat_val(tag, k), "R5 wrapped placement",
                line_data[sl*64 +: 64], beat_val(tag, k));
        end
        @(posedge clk); @(negedge clk);
        chk(!line_done && !crit_pulse, "R7 done single cycle", {line_done, crit_pulse}, 0);
        chk(line_err == (errmask != 0), "R8 error stays set", line_err, errmask != 0);
        if (ign) chk(!m_arvalid && !fill_busy, "R9 competing request ignored", m_arvalid, 0);
    endtask

    task automatic t_reject;
        @(negedge clk);
        miss_valid = 1; miss_cnns = 0; miss_addr = 32'h0000_1238;
        @(posedge clk); @(negedge clk);
        miss_valid = 0;
        chk(req_reject && !m_arvalid && !fill_busy, "R3 refusal pulse",
            {req_reject, m_arvalid, fill_busy}, 3'b100);
        @(posedge clk); @(negedge clk);
        chk(!req_reject && !m_arvalid, "R3 single pulse, no request", {req_reject, m_arvalid}, 0);
    endtask

    initial begin
        t_reset();
        t_fill(32'h1000_0000, 0, 4'b0000, 0, 1);
        t_fill(32'h1000_004D, 2, 4'b0000, 0, 2);
        t_fill(32'h2000_0113, 0, 4'b1000, 0, 3);
        t_fill(32'h3000_03F9, 1, 4'b0000, 1, 4);
        t_fill(32'h4000_0A28, 0, 4'b0001, 0, 5);
        t_reject();
        t_fill(32'h5000_0010, 0, 4'b0000, 0, 6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule